// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of one PCI function's configuration space. The bus interface logic drives one-cycle strobes when an error event happens: an address or data parity error, a system error, a master abort or target abort on a cycle the function started, or a target abort the function issued itself. Each strobe sets a sticky flag in the word. A flag stays set until configuration software writes a 1 to its position. Writing 0 to a position leaves it alone.

A separate data-parity flag sets only under three conditions at once. PERR must be seen on the bus, the function must have been bus master in that data phase, and the PERR response enable from the command register must be on. The word also holds fixed fields: the DEVSEL timing code, the capabilities-list indicator and zeros in the unsupported positions. It also carries a live copy of the function's interrupt level. The block drives the INTx pin from that level, gated by the interrupt-disable bit from the command register. The disable bit never alters the status copy of the level.

The read port is combinational and returns the assembled word. A write with byte enables takes effect at the next clock edge.

Top module: `pci_cfg_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) all sticky flags are 0, so with int_src_i low the read word is 16'h0210.
- R2: Bits 10:9 always read 01 and bit 4 always reads 1. Bits 7:5 and 2:0 always read 0. Configuration writes of any value do not change these bits.
- R3: Bit 15 reads 1 from the clock edge that samples ev_addr_par_i or ev_data_par_i high.
- R4: Bit 14 sets at the edge that samples ev_sys_err_i high together with serr_en_i high. ev_sys_err_i with serr_en_i low does not set it.
- R5: Bit 13 sets on ev_mabort_i. Bit 12 sets on ev_tabt_rx_i. Bit 11 sets on ev_tabt_tx_i. Each sets at the sampling edge.
- R6: Bit 8 sets only when perr_seen_i, bus_master_i and perr_resp_en_i are all high in the same cycle. Any partial combination leaves it unchanged.
- R7: A write (cfg_wr_i high) clears every sticky bit (15:11, 8) whose cfg_wdata_i bit is 1, at the next edge. A written 0 leaves the flag unchanged, and flags hold when no write or event occurs.
- R8: Clearing is qualified by byte enables. cfg_be_i[1] gates bits 15:8 and cfg_be_i[0] gates bits 7:0. A write with cfg_be_i[1] low clears no sticky flag.
- R9: When a set event and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R10: Bit 3 equals int_src_i in the same cycle. It ignores writes and is unaffected by int_dis_i.
- R11: intx_o is high exactly when int_src_i is high and int_dis_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_addr_par_i | input | 1 | Address parity error detected strobe |
| ev_data_par_i | input | 1 | Data parity error detected strobe |
| ev_sys_err_i | input | 1 | System error signaled strobe |
| serr_en_i | input | 1 | System error reporting enable |
| ev_mabort_i | input | 1 | Own cycle ended by master abort |
| ev_tabt_rx_i | input | 1 | Own cycle ended by target abort |
| ev_tabt_tx_i | input | 1 | Function terminated a transaction with target abort |
| perr_seen_i | input | 1 | PERR observed from any agent |
| bus_master_i | input | 1 | Function was master in that data phase |
| perr_resp_en_i | input | 1 | Command register PERR response enable |
| int_dis_i | input | 1 | Command register interrupt disable |
| int_src_i | input | 1 | Internal interrupt request level |
| cfg_wr_i | input | 1 | Configuration write strobe for this register |
| cfg_be_i | input | 2 | Write byte enables |
| cfg_wdata_i | input | 16 | Write data, 1 clears a sticky flag |
| rd_data_o | output | 16 | Assembled status word |
| intx_o | output | 1 | Gated interrupt pin, active high |

## Verification
Every sticky flag is read combinationally, so a flag in a wrong state shows on rd_data_o in the cycle after the edge that corrupted it. The bench compares the full word and intx_o against its model once per clock. The same comparison catches a missed set, a clear in the wrong byte lane, and a clear that wins over a set. Gating faults are also caught this way: a system-error or data-parity flag set when its enable was off, or an INTx that follows the disable bit wrongly. Fixed fields and the interrupt copy are compared on every cycle, including cycles with all-ones writes.

// File: rtl/pcs_pkg.sv
// Package: shared constants and types for the configuration status register.
// Assumes a 16-bit status word with fixed bit positions decoded by software.
package pcs_pkg;
    localparam int STAT_W      = 16;
    localparam int BIT_PAR     = 15;
    localparam int BIT_SERR    = 14;
    localparam int BIT_MABT    = 13;
    localparam int BIT_TABT_RX = 12;
    localparam int BIT_TABT_TX = 11;
    localparam int BIT_DPAR    = 8;
    localparam int BIT_INT     = 3;

    // Positions that hold write-one-to-clear flags.
    localparam logic [STAT_W-1:0] STICKY_MASK = 16'hF900;
    // Hardwired content: DEVSEL timing 01 at 10:9, capability list at 4.
    localparam logic [STAT_W-1:0] FIXED_VALUE = 16'h0210;

    typedef struct packed {
        logic addr_par;
        logic data_par;
        logic sys_err;
        logic serr_en;
        logic mabort;
        logic tabt_rx;
        logic tabt_tx;
        logic perr_seen;
        logic bus_master;
        logic perr_resp_en;
    } pcs_events_t;
endpackage

// File: rtl/pcs_event_map.sv
// Module: pcs_event_map
// Turns the bus-side event strobes into a per-bit set vector for the status word.
// Assumes strobes are single-cycle and already synchronous to clk.
module pcs_event_map
    import pcs_pkg::*;
#(
    parameter int W = pcs_pkg::STAT_W
) (
    input  pcs_events_t  ev_i,
    output logic [W-1:0] set_o
);
    logic dpar_qual;

    // Data parity flag needs PERR seen, own mastership and response enabled.
    always_comb dpar_qual = ev_i.perr_seen & ev_i.bus_master & ev_i.perr_resp_en;

    // Route each qualified event to its bit position.
    always_comb begin
        set_o              = '0;
        set_o[BIT_PAR]     = ev_i.addr_par | ev_i.data_par;
        set_o[BIT_SERR]    = ev_i.sys_err & ev_i.serr_en;
        set_o[BIT_MABT]    = ev_i.mabort;
        set_o[BIT_TABT_RX] = ev_i.tabt_rx;
        set_o[BIT_TABT_TX] = ev_i.tabt_tx;
        set_o[BIT_DPAR]    = dpar_qual;
    end
endmodule

// File: rtl/pcs_w1c_cell.sv
// Module: pcs_w1c_cell
// One sticky status flag: set by an event, cleared by a write of 1, set wins.
// Assumes synchronous active-low reset and a single clock domain.
module pcs_w1c_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    // Flag storage: reset to 0, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_r <= 1'b0;
        else if (set_i)  q_r <= 1'b1;
        else if (clr_i)  q_r <= 1'b0;
    end

    assign q_o = q_r;

    // R9: a set in the same cycle as a clear leaves the flag at 1.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R7: a clear without a set empties the flag.
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R7: with no set and no clear the flag holds.
    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/pcs_intx_gate.sv
// Module: pcs_intx_gate
// Produces the interrupt status copy and the gated INTx pin.
// Assumes int_src_i is a level from the function's interrupt sources.
module pcs_intx_gate (
    input  logic int_src_i,
    input  logic int_dis_i,
    output logic int_stat_o,
    output logic intx_o
);
    // Status copy follows the source regardless of the disable bit.
    always_comb int_stat_o = int_src_i;
    // Pin asserts only for a pending request while not disabled.
    always_comb intx_o = int_src_i & ~int_dis_i;
endmodule

// File: rtl/pci_cfg_status.sv
// Module: pci_cfg_status
// PCI configuration status word for one function: sticky error flags with
// byte-qualified write-one-to-clear, hardwired fields, interrupt status and INTx.
// Assumes cfg_wr_i is already decoded for this register's address.
module pci_cfg_status
    import pcs_pkg::*;
#(
    parameter int STAT_W = pcs_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_addr_par_i,
    input  logic              ev_data_par_i,
    input  logic              ev_sys_err_i,
    input  logic              serr_en_i,
    input  logic              ev_mabort_i,
    input  logic              ev_tabt_rx_i,
    input  logic              ev_tabt_tx_i,
    input  logic              perr_seen_i,
    input  logic              bus_master_i,
    input  logic              perr_resp_en_i,
    input  logic              int_dis_i,
    input  logic              int_src_i,
    input  logic              cfg_wr_i,
    input  logic [STAT_W/8-1:0] cfg_be_i,
    input  logic [STAT_W-1:0] cfg_wdata_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              intx_o
);
    localparam int BE_W = STAT_W / 8;

    pcs_events_t        ev;
    logic [STAT_W-1:0]  set_vec;
    logic [STAT_W-1:0]  clr_vec;
    logic [STAT_W-1:0]  flag_q;
    logic               int_stat;
    logic               unused_bits;

    // Bundle the bus-side strobes for the event mapper.
    always_comb begin
        ev.addr_par     = ev_addr_par_i;
        ev.data_par     = ev_data_par_i;
        ev.sys_err      = ev_sys_err_i;
        ev.serr_en      = serr_en_i;
        ev.mabort       = ev_mabort_i;
        ev.tabt_rx      = ev_tabt_rx_i;
        ev.tabt_tx      = ev_tabt_tx_i;
        ev.perr_seen    = perr_seen_i;
        ev.bus_master   = bus_master_i;
        ev.perr_resp_en = perr_resp_en_i;
    end

    pcs_event_map #(.W(STAT_W)) u_event_map (
        .ev_i  (ev),
        .set_o (set_vec)
    );

    // Byte-lane qualified clear request per bit.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign clr_vec[b*8 +: 8] = {8{cfg_wr_i & cfg_be_i[b]}} & cfg_wdata_i[b*8 +: 8];
    end

    // Sticky cells only where the mask says; other positions hold no state.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            pcs_w1c_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (flag_q[i])
            );
        end else begin : g_none
            assign flag_q[i] = 1'b0;
        end
    end

    // Lanes and events that land on non-sticky positions are discarded.
    assign unused_bits = ^((set_vec | clr_vec) & ~STICKY_MASK);

    pcs_intx_gate u_intx (
        .int_src_i  (int_src_i),
        .int_dis_i  (int_dis_i),
        .int_stat_o (int_stat),
        .intx_o     (intx_o)
    );

    // Assemble the read word from flags, fixed fields and interrupt status.
    always_comb begin
        rd_data_o          = flag_q | FIXED_VALUE;
        rd_data_o[BIT_INT] = int_stat;
    end

    // R4: with reporting disabled a clear system-error flag stays clear.
    assert_serr_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!serr_en_i && !rd_data_o[BIT_SERR]) |=> !rd_data_o[BIT_SERR]);
    // R6: without PERR response enable a clear data-parity flag stays clear.
    assert_dpar_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_resp_en_i && !rd_data_o[BIT_DPAR]) |=> !rd_data_o[BIT_DPAR]);
    // R8: a write without the upper enable and no events keeps the upper flags.
    assert_upper_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_be_i[1] && set_vec == '0) |=> $stable(rd_data_o[15:8]));
    // R11: the pin only asserts with interrupt status set and disable clear.
    assert_intx_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        intx_o |-> (rd_data_o[BIT_INT] && !int_dis_i));
endmodule

// File: tb/pci_cfg_status_bench.sv
// Bench: behavioural model of the status word compared on every clock.
module pci_cfg_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_addr_par = 0, ev_data_par = 0, ev_sys_err = 0, serr_en = 0;
    logic ev_mabort = 0, ev_tabt_rx = 0, ev_tabt_tx = 0;
    logic perr_seen = 0, bus_master = 0, perr_resp_en = 0;
    logic int_dis = 0, int_src = 0, cfg_wr = 0;
    logic [1:0]  cfg_be = 0;
    logic [15:0] cfg_wdata = 0;
    logic [15:0] rd_data;
    logic        intx;

    int checks = 0;
    int errors = 0;
    int model_flags = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pci_cfg_status u_pci_cfg_status (
        .clk(clk), .rst_n(rst_n),
        .ev_addr_par_i(ev_addr_par), .ev_data_par_i(ev_data_par),
        .ev_sys_err_i(ev_sys_err), .serr_en_i(serr_en),
        .ev_mabort_i(ev_mabort), .ev_tabt_rx_i(ev_tabt_rx), .ev_tabt_tx_i(ev_tabt_tx),
        .perr_seen_i(perr_seen), .bus_master_i(bus_master), .perr_resp_en_i(perr_resp_en),
        .int_dis_i(int_dis), .int_src_i(int_src),
        .cfg_wr_i(cfg_wr), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata),
        .rd_data_o(rd_data), .intx_o(intx)
    );

    function automatic int expected_word();
        return model_flags + 'h200 + 'h10 + (int_src ? 8 : 0);
    endfunction

    task automatic compare(input string tag);
        int exp_w;
        int exp_i;
        exp_w = expected_word();
        exp_i = (int_src && !int_dis) ? 1 : 0;
        checks++;
        if (int'(rd_data) != exp_w) begin
            errors++;
            $display("FAIL %s word actual %h expected %h", tag, rd_data, exp_w[15:0]);
        end
        checks++;
        if (int'(intx) != exp_i) begin
            errors++;
            $display("FAIL %s intx actual %0d expected %0d", tag, intx, exp_i);
        end
    endtask

    // Model update at an edge: flags are bits 15..11 and 8.
    task automatic model_edge();
        int setv;
        int clrv;
        if (!rst_n) begin
            model_flags = 0;
            return;
        end
        setv = 0;
        if (ev_addr_par || ev_data_par)            setv += 'h8000;
        if (ev_sys_err && serr_en)                 setv += 'h4000;
        if (ev_mabort)                             setv += 'h2000;
        if (ev_tabt_rx)                            setv += 'h1000;
        if (ev_tabt_tx)                            setv += 'h0800;
        if (perr_seen && bus_master && perr_resp_en) setv += 'h0100;
        clrv = 0;
        if (cfg_wr && cfg_be[1]) clrv = int'(cfg_wdata) & 'hF900;
        model_flags = (model_flags & ~clrv) | setv;
    endtask

    // Called at a negedge with inputs set: compare, take the edge, return at negedge.
    task automatic tick(input string tag);
        #1 compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        {ev_addr_par, ev_data_par, ev_sys_err, ev_mabort, ev_tabt_rx, ev_tabt_tx} = '0;
        {perr_seen, bus_master, perr_resp_en} = '0;
        cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        cfg_wr = 1; cfg_be = be; cfg_wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tick("R1 in reset");
        rst_n = 1;
        tick("R1 after reset");
        // R1: reset word is exactly 0210
        checks++;
        if (rd_data !== 16'h0210) begin
            errors++;
            $display("FAIL R1 reset word actual %h expected 0210", rd_data);
        end

        // R2: all-ones writes leave fixed fields alone
        wr(2'b11, 16'hFFFF); tick("R2 write ones");
        wr(2'b11, 16'h0000); tick("R2 write zeros");
        idle(); tick("R2 after writes");

        // R3: both parity sources
        ev_addr_par = 1; tick("R3 addr parity"); idle(); tick("R3 flag set");
        wr(2'b10, 16'h8000); tick("R7 clear 15"); idle(); tick("R7 cleared");
        ev_data_par = 1; tick("R3 data parity"); idle(); tick("R3 flag set");

        // R4: system error gating
        ev_sys_err = 1; serr_en = 0; tick("R4 disabled"); idle(); tick("R4 stays 0");
        ev_sys_err = 1; serr_en = 1; tick("R4 enabled"); idle(); tick("R4 set");

        // R5: abort flags one at a time
        ev_mabort = 1; tick("R5 mabort"); idle(); tick("R5 bit13");
        ev_tabt_rx = 1; tick("R5 tabt rx"); idle(); tick("R5 bit12");
        ev_tabt_tx = 1; tick("R5 tabt tx"); idle(); tick("R5 bit11");

        // R6: every partial combination, then all three
        for (int c = 0; c < 8; c++) begin
            {perr_seen, bus_master, perr_resp_en} = c[2:0];
            tick("R6 combo");
            idle();
            tick("R6 after combo");
        end

        // R8: lower lane only clears nothing; R7: zeros clear nothing
        wr(2'b01, 16'hFFFF); tick("R8 lower lane"); idle(); tick("R8 flags kept");
        wr(2'b10, 16'h0000); tick("R7 zeros"); idle(); tick("R7 flags kept");
        wr(2'b10, 16'h2100); tick("R7 partial"); idle(); tick("R7 partial cleared");

        // R9: set and clear together
        ev_tabt_tx = 1; wr(2'b11, 16'hFFFF); tick("R9 collide"); idle(); tick("R9 bit11 kept");
        wr(2'b11, 16'hFFFF); tick("R7 clear all"); idle(); tick("R7 empty");

        // R10, R11: interrupt level and disable
        int_src = 1; int_dis = 0; tick("R10 level"); tick("R11 pin on");
        int_dis = 1; tick("R11 pin masked");
        wr(2'b11, 16'h0008); tick("R10 write ignored"); idle();
        int_src = 0; tick("R10 level low"); int_dis = 0; tick("R11 pin off");

        // R9 and R7 under random traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            {ev_addr_par, ev_data_par, ev_sys_err, serr_en, ev_mabort, ev_tabt_rx, ev_tabt_tx} = 7'(r[6:0] & r[13:7]);
            {perr_seen, bus_master, perr_resp_en} = r[16:14];
            {int_dis, int_src} = r[18:17];
            cfg_wr = r[19]; cfg_be = r[21:20];
            cfg_wdata = 16'($urandom);
            tick("R9 random");
        end
        idle(); tick("R7 final");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule